// File: doc/BRIEF.md
# Radix Effective-Address Qualifier

This block sits in front of a radix page-table walker. Each request carries a 64-bit effective address together with the hypervisor-state bit, a flag that says relocation is off, the access type, and the current partition-ID, process-ID and real-mode offset registers. The block sorts each request into one of three outcomes. It can finish it at once as a hypervisor real-mode access. It can reject it with a segment fault. Otherwise it hands the walker the partition and process IDs to use, plus the stages the walk must run.

The two top address bits form a quadrant. The quadrant picks the partition and process IDs from the incoming registers. Hypervisor state and guest state use different mapping tables, and two guest quadrants are not allowed. Any set bit in the ten address bits just below the quadrant is also a fault. A data-side segment fault records the faulting address in a holding register.

The decision logic is combinational and feeds a single registered output stage. The result appears one cycle after the input strobe.

Top module: `radix_addr_qualifier`

## Requirements
- R1: `out_valid` is high for exactly the cycle after each cycle with `in_valid` high. While `out_valid` is high, exactly one of `done_real`, `walk_req` and `seg_fault` is high. While `out_valid` is low, all three are low.
- R2: A request that is not hypervisor real mode (`real_mode`=1 and `hv_state`=1) faults when any of address bits 61:52 is set.
- R3: With `hv_state`=1 and a walk granted, the quadrant `ea[63:62]` gives (`lpid_out`, `pid_out`) as follows: 0 gives (0, `pid_reg`), 1 gives (`lpid_reg`, `pid_reg`), 2 gives (`lpid_reg`, 0), 3 gives (0, 0).
- R4: With `hv_state`=0, quadrant 0 gives (`lpid_reg`, `pid_reg`) and quadrant 3 gives (`lpid_reg`, 0). Quadrants 1 and 2 raise `seg_fault`.
- R5: On a segment fault, `seg_inst` is 1 when `acc_type`=0 (instruction fetch) and 0 for a data access (`acc_type` 1 = load, 2 or 3 = store). `fault_addr` takes the effective address on data segment faults only. It keeps its value for every other request.
- R6: With `real_mode`=1 and `hv_state`=1, `done_real` is asserted and `real_addr` is `ea` with bits 63:60 cleared. When `ea[63]`=0, `hrmor` is ORed in as well. `perm_rwx` is 3'b111 (read, write, execute) on such a result and 3'b000 on any other result.
- R7: On a walk, `need_part` is 1 exactly when `lpid_out` is nonzero or the request was in guest state.
- R8: On a walk, `need_proc` equals the inverse of `real_mode`. `guest_raddr` is `ea` with bits 63:62 cleared, and it is the address the partition stage uses when `need_proc`=0.
- R9: After reset, `out_valid`, `done_real`, `walk_req`, `seg_fault` and `fault_addr` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Request strobe |
| ea | input | 64 | Effective address |
| hv_state | input | 1 | Hypervisor state |
| real_mode | input | 1 | Relocation off |
| acc_type | input | 2 | 0 fetch, 1 load, 2/3 store |
| lpid_reg | input | 32 | Partition-ID register |
| pid_reg | input | 32 | Process-ID register |
| hrmor | input | 64 | Real-mode offset register |
| out_valid | output | 1 | Result valid |
| done_real | output | 1 | Finished as hypervisor real-mode access |
| walk_req | output | 1 | Table walk requested |
| seg_fault | output | 1 | Segment fault |
| seg_inst | output | 1 | Fault is on the instruction side |
| real_addr | output | 64 | Direct real address |
| perm_rwx | output | 3 | Granted read/write/execute |
| lpid_out | output | 32 | Partition ID for the walk |
| pid_out | output | 32 | Process ID for the walk |
| need_proc | output | 1 | Process-scoped stage needed |
| need_part | output | 1 | Partition-scoped stage needed |
| guest_raddr | output | 64 | Quadrant-stripped address |
| fault_addr | output | 64 | Last data segment fault address |

## Verification
The hardest case to reach is the interaction of the two fault sources with hypervisor real mode. Real mode must skip both the gap-bit check and the quadrant check. A data fault must move `fault_addr`, while a fetch fault and every other request must leave it alone. Uniform random addresses would almost always set a gap bit, so the stimulus clears the gap field in most vectors and sets a single random gap bit in the rest. It also crosses every quadrant with both values of the hypervisor bit, both values of the relocation flag and all access types. Directed vectors pin down the offset-register rule at address bit 63 and the zero-partition-ID case in hypervisor state.

// File: rtl/radq_pkg.sv
package radq_pkg;
  typedef enum logic [1:0] {
    ACC_FETCH = 2'd0,
    ACC_LOAD  = 2'd1,
    ACC_STORE = 2'd2,
    ACC_STORE2 = 2'd3
  } acc_e;
endpackage

// File: rtl/radq_qmap.sv
// Quadrant to (partition ID, process ID) mapping, one table per privilege state.
module radq_qmap #(
  parameter int ID_W = 32
) (
  input  logic [1:0]      quad,
  input  logic            hv,
  input  logic [ID_W-1:0] lpid_reg,
  input  logic [ID_W-1:0] pid_reg,
  output logic [ID_W-1:0] lpid,
  output logic [ID_W-1:0] pid,
  output logic            illegal
);
  always_comb begin
    lpid    = '0;
    pid     = '0;
    illegal = 1'b0;
    if (hv) begin
      unique case (quad)
        2'd0: pid = pid_reg;
        2'd1: begin lpid = lpid_reg; pid = pid_reg; end
        2'd2: lpid = lpid_reg;
        default: ;
      endcase
    end else begin
      unique case (quad)
        2'd0: begin lpid = lpid_reg; pid = pid_reg; end
        2'd3: lpid = lpid_reg;
        default: illegal = 1'b1;
      endcase
    end
  end
endmodule

// File: rtl/radq_real.sv
// Hypervisor real-mode address: strip top bits, add offset when MSB clear.
module radq_real #(
  parameter int EA_W  = 64,
  parameter int CLR_W = 4
) (
  input  logic [EA_W-1:0] ea,
  input  logic [EA_W-1:0] hrmor,
  output logic [EA_W-1:0] raddr
);
  localparam logic [EA_W-1:0] KEEP = {{CLR_W{1'b0}}, {(EA_W-CLR_W){1'b1}}};
  always_comb begin
    raddr = ea & KEEP;
    if (!ea[EA_W-1]) raddr = raddr | hrmor;
  end
endmodule

// File: rtl/radix_addr_qualifier.sv
module radix_addr_qualifier #(
  parameter int EA_W   = 64,
  parameter int ID_W   = 32,
  parameter int QUAD_W = 2,
  parameter int GAP_W  = 10,
  parameter int CLR_W  = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  input  logic [EA_W-1:0] ea,
  input  logic            hv_state,
  input  logic            real_mode,
  input  logic [1:0]      acc_type,
  input  logic [ID_W-1:0] lpid_reg,
  input  logic [ID_W-1:0] pid_reg,
  input  logic [EA_W-1:0] hrmor,
  output logic            out_valid,
  output logic            done_real,
  output logic            walk_req,
  output logic            seg_fault,
  output logic            seg_inst,
  output logic [EA_W-1:0] real_addr,
  output logic [2:0]      perm_rwx,
  output logic [ID_W-1:0] lpid_out,
  output logic [ID_W-1:0] pid_out,
  output logic            need_proc,
  output logic            need_part,
  output logic [EA_W-1:0] guest_raddr,
  output logic [EA_W-1:0] fault_addr
);
  import radq_pkg::*;

  localparam int QLO    = EA_W - QUAD_W;
  localparam int GAP_HI = QLO - 1;
  localparam logic [EA_W-1:0] QMASK = {{QUAD_W{1'b0}}, {QLO{1'b1}}};

  // Decode
  logic [ID_W-1:0] map_lpid, map_pid;
  logic            map_illegal;
  logic [EA_W-1:0] rm_addr;
  logic            hv_real, gap_bad, fault_d, walk_d, inst_d, part_d;
  acc_e            acc;

  radq_qmap #(.ID_W(ID_W)) u_qmap (
    .quad(ea[EA_W-1 -: QUAD_W]), .hv(hv_state),
    .lpid_reg(lpid_reg), .pid_reg(pid_reg),
    .lpid(map_lpid), .pid(map_pid), .illegal(map_illegal)
  );

  radq_real #(.EA_W(EA_W), .CLR_W(CLR_W)) u_real (
    .ea(ea), .hrmor(hrmor), .raddr(rm_addr)
  );

  always_comb begin
    acc     = acc_e'(acc_type);
    hv_real = real_mode & hv_state;
    gap_bad = |ea[GAP_HI -: GAP_W];
    fault_d = ~hv_real & (gap_bad | map_illegal);
    walk_d  = ~hv_real & ~fault_d;
    inst_d  = (acc == ACC_FETCH);
    part_d  = (|map_lpid) | ~hv_state;
  end

  // Next-state
  logic            vld_n, done_n, walk_n, flt_n;
  logic [EA_W-1:0] fa_n;
  logic            fa_en, dat_en;

  always_comb begin
    vld_n  = in_valid;
    done_n = in_valid & hv_real;
    walk_n = in_valid & walk_d;
    flt_n  = in_valid & fault_d;
    dat_en = in_valid;
    fa_en  = in_valid & fault_d & ~inst_d;
    fa_n   = ea;
  end

  // Registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      done_real  <= 1'b0;
      walk_req   <= 1'b0;
      seg_fault  <= 1'b0;
      fault_addr <= '0;
    end else begin
      out_valid <= vld_n;
      done_real <= done_n;
      walk_req  <= walk_n;
      seg_fault <= flt_n;
      if (fa_en) fault_addr <= fa_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seg_inst    <= 1'b0;
      real_addr   <= '0;
      perm_rwx    <= '0;
      lpid_out    <= '0;
      pid_out     <= '0;
      need_proc   <= 1'b0;
      need_part   <= 1'b0;
      guest_raddr <= '0;
    end else if (dat_en) begin
      seg_inst    <= inst_d;
      real_addr   <= rm_addr;
      perm_rwx    <= hv_real ? 3'b111 : 3'b000;
      lpid_out    <= map_lpid;
      pid_out     <= map_pid;
      need_proc   <= ~real_mode;
      need_part   <= part_d;
      guest_raddr <= ea & QMASK;
    end
  end
endmodule

// File: rtl/radq_checker.sv
module radq_checker #(
  parameter int EA_W = 64,
  parameter int ID_W = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic            in_valid,
  input logic            hv_state,
  input logic [ID_W-1:0] lpid_reg,
  input logic            out_valid,
  input logic            done_real,
  input logic            walk_req,
  input logic            seg_fault,
  input logic            seg_inst,
  input logic [2:0]      perm_rwx,
  input logic [ID_W-1:0] lpid_out,
  input logic            need_part,
  input logic [EA_W-1:0] fault_addr
);
  p_follow_r1: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  p_onehot_r1: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $countones({done_real, walk_req, seg_fault}) == 1);
  p_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> !(done_real || walk_req || seg_fault));
  p_perm_r6: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (perm_rwx == (done_real ? 3'b111 : 3'b000)));
  p_part_r7: assert property (@(posedge clk) disable iff (!rst_n)
    walk_req |-> need_part == ((lpid_out != '0) || !$past(hv_state)));
  p_guest_lpid_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (walk_req && !$past(hv_state)) |-> lpid_out == $past(lpid_reg));
  p_fa_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(seg_fault && !seg_inst) |-> $stable(fault_addr));
endmodule

bind radix_addr_qualifier radq_checker #(.EA_W(EA_W), .ID_W(ID_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .hv_state(hv_state),
  .lpid_reg(lpid_reg), .out_valid(out_valid), .done_real(done_real),
  .walk_req(walk_req), .seg_fault(seg_fault), .seg_inst(seg_inst),
  .perm_rwx(perm_rwx), .lpid_out(lpid_out), .need_part(need_part),
  .fault_addr(fault_addr)
);

// File: tb/tb_radix_addr_qualifier.sv
module tb_radix_addr_qualifier;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid;
  logic [63:0] ea, hrmor;
  logic        hv_state, real_mode;
  logic [1:0]  acc_type;
  logic [31:0] lpid_reg, pid_reg;
  logic        out_valid, done_real, walk_req, seg_fault, seg_inst;
  logic [63:0] real_addr, guest_raddr, fault_addr;
  logic [2:0]  perm_rwx;
  logic [31:0] lpid_out, pid_out;
  logic        need_proc, need_part;

  int checks = 0;
  int errors = 0;
  logic [63:0] exp_fa;

  always #10 clk = ~clk;

  radix_addr_qualifier dut (.*);

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Model outcome: 0 real, 1 walk, 2 fault
  function automatic int outcome(input logic [63:0] a, input logic hv, input logic rm);
    if (rm && hv) return 0;
    if (a[61:52] != 0) return 2;
    if (!hv && (a[63:62] == 2'd1 || a[63:62] == 2'd2)) return 2;
    return 1;
  endfunction

  function automatic logic [31:0] m_lpid(input logic [1:0] q, input logic hv,
                                        input logic [31:0] l);
    if (hv) return (q == 2'd1 || q == 2'd2) ? l : 32'd0;
    return l;
  endfunction

  function automatic logic [31:0] m_pid(input logic [1:0] q, input logic hv,
                                       input logic [31:0] p);
    if (hv) return (q == 2'd0 || q == 2'd1) ? p : 32'd0;
    return (q == 2'd0) ? p : 32'd0;
  endfunction

  task automatic run(input logic [63:0] a, input logic hv, input logic rm,
                     input logic [1:0] at, input logic [31:0] l, input logic [31:0] p,
                     input logic [63:0] off);
    int oc;
    logic [63:0] ra;
    logic [31:0] el;
    ea = a; hv_state = hv; real_mode = rm; acc_type = at;
    lpid_reg = l; pid_reg = p; hrmor = off; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    oc = outcome(a, hv, rm);
    chk("R1 out_valid", 64'(out_valid), 64'd1);
    chk("R1 flags", {61'd0, done_real, walk_req, seg_fault},
        {61'd0, oc == 0, oc == 1, oc == 2});
    if (oc == 2) begin
      chk("R5 seg_inst", 64'(seg_inst), 64'(at == 2'd0));
      if (at != 2'd0) exp_fa = a;
    end
    chk("R5 fault_addr", fault_addr, exp_fa);
    chk("R6 perm", 64'(perm_rwx), (oc == 0) ? 64'd7 : 64'd0);
    if (oc == 0) begin
      ra = a & 64'h0FFF_FFFF_FFFF_FFFF;
      if (!a[63]) ra = ra | off;
      chk("R6 real_addr", real_addr, ra);
    end
    if (oc == 1) begin
      el = m_lpid(a[63:62], hv, l);
      chk(hv ? "R3 lpid" : "R4 lpid", 64'(lpid_out), 64'(el));
      chk(hv ? "R3 pid" : "R4 pid", 64'(pid_out), 64'(m_pid(a[63:62], hv, p)));
      chk("R7 need_part", 64'(need_part), 64'((el != 0) || !hv));
      chk("R8 need_proc", 64'(need_proc), 64'(!rm));
      chk("R8 guest_raddr", guest_raddr, a & 64'h3FFF_FFFF_FFFF_FFFF);
    end
    @(negedge clk);
    chk("R1 idle", {61'd0, out_valid, done_real, walk_req, seg_fault}, 64'd0);
  endtask

  initial begin
    #(20 * 200000);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int seed;
    seed = 32'h5eed_0042;
    void'($urandom(seed));
    rst_n = 1'b0; in_valid = 1'b0; ea = '0; hv_state = 1'b0; real_mode = 1'b0;
    acc_type = 2'd0; lpid_reg = '0; pid_reg = '0; hrmor = '0; exp_fa = '0;
    repeat (3) @(negedge clk);
    chk("R9 reset flags", {60'd0, out_valid, done_real, walk_req, seg_fault}, 64'd0);
    chk("R9 reset fault_addr", fault_addr, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    // Directed corners
    run(64'h0123_0000_0000_1000, 1, 1, 2'd1, 32'd5, 32'd6, 64'h0000_0040_0000_0000); // R6 MSB clear
    run(64'hF000_0000_0000_2000, 1, 1, 2'd0, 32'd5, 32'd6, 64'h0000_0040_0000_0000); // R6 MSB set
    run(64'h0030_0000_0000_0000, 1, 1, 2'd1, 32'd5, 32'd6, 64'd0); // R2 skipped in real mode
    run(64'h0010_0000_0000_0000, 1, 0, 2'd1, 32'd5, 32'd6, 64'd0); // R2 data fault
    run(64'h2000_0000_0000_0000, 1, 0, 2'd0, 32'd5, 32'd6, 64'd0); // R2 fetch fault
    run(64'h4000_0000_0000_0000, 0, 0, 2'd2, 32'd5, 32'd6, 64'd0); // R4 q1 illegal
    run(64'h8000_0000_0000_0000, 0, 1, 2'd0, 32'd5, 32'd6, 64'd0); // R4 q2 fetch
    run(64'h0000_0000_0000_0008, 1, 0, 2'd1, 32'd9, 32'd6, 64'd0); // R7 hv lpid 0
    run(64'h4000_0000_0000_0008, 1, 0, 2'd1, 32'd0, 32'd6, 64'd0); // R7 hv q1 lpid reg 0
    run(64'hC000_0000_0000_0008, 0, 1, 2'd2, 32'd0, 32'd6, 64'd0); // R7 guest, R8 real
    for (int i = 0; i < 600; i++) begin
      logic [63:0] a;
      a = {$urandom, $urandom};
      a[61:52] = 10'd0;
      if ($urandom_range(0, 7) == 0) a[52 + $urandom_range(0, 9)] = 1'b1;
      run(a, 1'($urandom), 1'($urandom), 2'($urandom), $urandom_range(0, 3) == 0 ? 32'd0 : $urandom,
          $urandom, {$urandom, $urandom});
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule